// File: doc/BRIEF.md
# Paired Floating-Point Load Issue Control

This block sits between instruction decode and the load pipeline for a load that fills two floating-point registers from one memory access. It takes a decoded request through a valid/ready handshake. The request carries the element form, a base-update flag, a speculative flag, two register specifiers, the current rotation base for the rotating register file, the base address register and that register's NaT bit. One cycle after it accepts a request, the block presents a single response. The response gives the memory access (address and byte count), the base register write-back, an optional prefetch hint and the two physical target indices. It also reports either a fault, a deferred-exception marker or clean completion, together with the low and high FP-modified status flags.

After a request that issues a memory access is accepted, the block holds `req_ready` low until the data beat returns. It then splits that beat into two register writes, sending the lower-addressed element to the first target and the higher-addressed element to the second. Register rotation is resolved inside the block. A pair is legal only when its two physical indices have opposite parity. When one specifier is static and the other rotates, this means an odd rotation base reverses the parity rule that applies to the raw specifiers.

Top module: `fpair_ld_ctl`

## Requirements
- R1: `acc_addr` equals the request's base value. `acc_bytes` is 8 for form code 0 (single) and 16 for form codes 1 (double) and 2 (integer).
- R2: When a beat arrives, the write data is split by form. For single, `wr1_data` is beat bits [31:0] and `wr2_data` is bits [63:32], each zero-extended to 64 bits. For double and integer, `wr1_data` is bits [63:0] and `wr2_data` is bits [127:64]. `wr1_idx` and `wr2_idx` are the physical targets of the first and second specifier.
- R3: With the update flag set on a non-faulting request, `base_wr` is 1 and `base_new` is base+8 for single or base+16 for the other forms. With the update flag clear, `base_wr` is 0.
- R4: The base update never changes the access address. `acc_addr` is the old base value whether or not the update flag is set.
- R5: `pf_valid` is 1 only for an issued access that has the update flag set. In that case `pf_addr` equals `base_new` and `pf_hint` equals the request's hint.
- R6: Specifiers 0–31 map to themselves. A specifier s in 32–127 maps to 32 + ((s − 32 + rrb) mod 96), where rrb is in 0–95. The results appear on `tgt1` and `tgt2`.
- R7: `flt_illegal` is raised when the two physical targets have equal parity, or when the form code is 3.
- R8: A set NaT bit raises `flt_nat` on a non-speculative request. On a speculative request it raises `nat_deferred` instead, with no fault. A deferred request suppresses the access and the prefetch, but it still performs the base update and sets the modified flags. An illegal-operation fault takes priority over both NaT outcomes.
- R9: When either fault is raised, `acc_valid`, `base_wr`, `pf_valid`, `mfl_set` and `mfh_set` are all 0, and no beat write follows.
- R10: Each accepted request produces exactly one single-cycle `rsp_valid` pulse, with all response fields, in the cycle after acceptance.
- R11: After a request that issues an access, `req_ready` is 0 until a beat arrives. `wr_en` equals `beat_valid` while the block waits for that beat.
- R12: On a non-faulting request, `mfl_set` is 1 if either physical target lies in 2–31, and `mfh_set` is 1 if either lies in 32–127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_form | input | 2 | 0 single, 1 double, 2 integer, 3 reserved |
| req_upd | input | 1 | Base-update form |
| req_spec | input | 1 | Speculative load type |
| req_f1 | input | 7 | First register specifier |
| req_f2 | input | 7 | Second register specifier |
| req_rrb | input | 7 | Rotation base, 0–95 |
| req_base | input | 64 | Base register value |
| req_nat | input | 1 | NaT bit of the base register |
| req_hint | input | 2 | Locality hint |
| rsp_valid | output | 1 | Response pulse |
| acc_valid | output | 1 | Memory access issued |
| acc_addr | output | 64 | Access address |
| acc_bytes | output | 5 | Access size in bytes |
| base_wr | output | 1 | Base register write-back enable |
| base_new | output | 64 | Updated base value |
| pf_valid | output | 1 | Prefetch hint issued |
| pf_addr | output | 64 | Prefetch address |
| pf_hint | output | 2 | Prefetch locality |
| tgt1 | output | 7 | Physical index of first target |
| tgt2 | output | 7 | Physical index of second target |
| flt_illegal | output | 1 | Illegal-operation fault |
| flt_nat | output | 1 | NaT-consumption fault |
| nat_deferred | output | 1 | Exception deferred |
| mfl_set | output | 1 | Low FP-modified flag set |
| mfh_set | output | 1 | High FP-modified flag set |
| beat_valid | input | 1 | Returned data beat present |
| beat_data | input | 128 | Returned data |
| wr_en | output | 1 | Register write strobe |
| wr1_idx | output | 7 | First write index |
| wr1_data | output | 64 | First write data |
| wr2_idx | output | 7 | Second write index |
| wr2_data | output | 64 | Second write data |

## Verification
An error in the rotation arithmetic shows up on `tgt1`/`tgt2`, and it often flips `flt_illegal` in the same response cycle. Sweeping every specifier against several rotation bases, including an odd one, exposes this within the first few hundred requests. A wrong stored form or stored target shows up only later, on the beat write, as swapped or mis-sliced data. A stuck wait flag shows up as `req_ready` staying low, or rising early, in the cycle right after the beat arrives.

// File: rtl/fpair_pkg.sv
package fpair_pkg;
   typedef enum logic [1:0] {
      FORM_SGL = 2'd0,
      FORM_DBL = 2'd1,
      FORM_INT = 2'd2,
      FORM_RSV = 2'd3
   } form_e;

   localparam int SGL_BYTES  = 8;
   localparam int WIDE_BYTES = 16;
endpackage

// File: rtl/fpair_rot.sv
module fpair_rot #(
   parameter int FRW   = 7,
   parameter int NSTAT = 32,
   parameter int NROT  = 96
) (
   input  logic [FRW-1:0] spec,
   input  logic [FRW-1:0] rrb,
   output logic [FRW-1:0] phys
);
   localparam int SW = FRW + 1;
   logic          is_rot;
   logic [SW-1:0] offs;
   logic [SW-1:0] wrapped;

   always_comb begin
      is_rot  = ({1'b0, spec} >= SW'(NSTAT));
      offs    = {1'b0, spec} - SW'(NSTAT) + {1'b0, rrb};
      wrapped = (offs >= SW'(NROT)) ? offs - SW'(NROT) : offs;
      phys    = is_rot ? FRW'(wrapped + SW'(NSTAT)) : spec;
   end
endmodule

// File: rtl/fpair_addr.sv
module fpair_addr #(
   parameter int AW = 64
) (
   input  fpair_pkg::form_e form,
   input  logic [AW-1:0]    base,
   output logic [4:0]       bytes,
   output logic [AW-1:0]    next_base
);
   import fpair_pkg::*;
   always_comb begin
      bytes     = (form == FORM_SGL) ? 5'(SGL_BYTES) : 5'(WIDE_BYTES);
      next_base = base + AW'(bytes);
   end
endmodule

// File: rtl/fpair_legal.sv
module fpair_legal #(
   parameter int FRW   = 7,
   parameter int NSTAT = 32
) (
   input  fpair_pkg::form_e form,
   input  logic [FRW-1:0]   p1,
   input  logic [FRW-1:0]   p2,
   input  logic             nat,
   input  logic             spec,
   output logic             illegal,
   output logic             nat_fault,
   output logic             defer,
   output logic             lo_mod,
   output logic             hi_mod
);
   import fpair_pkg::*;
   function automatic logic in_low(input logic [FRW-1:0] p);
      return (p >= FRW'(2)) && (p < FRW'(NSTAT));
   endfunction

   always_comb begin
      illegal   = (form == FORM_RSV) || (p1[0] == p2[0]);
      nat_fault = !illegal && nat && !spec;
      defer     = !illegal && nat && spec;
      lo_mod    = !illegal && !nat_fault && (in_low(p1) || in_low(p2));
      hi_mod    = !illegal && !nat_fault &&
                  ((p1 >= FRW'(NSTAT)) || (p2 >= FRW'(NSTAT)));
   end
endmodule

// File: rtl/fpair_ld_ctl.sv
module fpair_ld_ctl #(
   parameter int AW    = 64,
   parameter int FRW   = 7,
   parameter int NSTAT = 32,
   parameter int NROT  = 96,
   parameter int DW    = 128,
   parameter int HW    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [1:0]      req_form,
   input  logic            req_upd,
   input  logic            req_spec,
   input  logic [FRW-1:0]  req_f1,
   input  logic [FRW-1:0]  req_f2,
   input  logic [FRW-1:0]  req_rrb,
   input  logic [AW-1:0]   req_base,
   input  logic            req_nat,
   input  logic [HW-1:0]   req_hint,
   output logic            rsp_valid,
   output logic            acc_valid,
   output logic [AW-1:0]   acc_addr,
   output logic [4:0]      acc_bytes,
   output logic            base_wr,
   output logic [AW-1:0]   base_new,
   output logic            pf_valid,
   output logic [AW-1:0]   pf_addr,
   output logic [HW-1:0]   pf_hint,
   output logic [FRW-1:0]  tgt1,
   output logic [FRW-1:0]  tgt2,
   output logic            flt_illegal,
   output logic            flt_nat,
   output logic            nat_deferred,
   output logic            mfl_set,
   output logic            mfh_set,
   input  logic            beat_valid,
   input  logic [DW-1:0]   beat_data,
   output logic            wr_en,
   output logic [FRW-1:0]  wr1_idx,
   output logic [DW/2-1:0] wr1_data,
   output logic [FRW-1:0]  wr2_idx,
   output logic [DW/2-1:0] wr2_data
);
   import fpair_pkg::*;

   localparam int HALF = DW / 2;
   localparam int QTR  = DW / 4;

   if (NSTAT + NROT != (1 << FRW)) begin : g_bad_regs
      $error("register file split does not fill the index space");
   end
   if (DW != 8 * WIDE_BYTES) begin : g_bad_beat
      $error("beat width must hold a wide pair");
   end

   form_e          form_in;
   form_e          form_q;
   logic [FRW-1:0] spec_in [2];
   logic [FRW-1:0] phys    [2];
   logic [4:0]     bytes_c;
   logic [AW-1:0]  next_c;
   logic           ill_c, natf_c, def_c, lo_c, hi_c;
   logic           waiting;
   logic           accept;

   assign form_in    = form_e'(req_form);
   assign spec_in[0] = req_f1;
   assign spec_in[1] = req_f2;

   for (genvar i = 0; i < 2; i++) begin : g_rot
      fpair_rot #(.FRW(FRW), .NSTAT(NSTAT), .NROT(NROT)) u_rot (
         .spec (spec_in[i]),
         .rrb  (req_rrb),
         .phys (phys[i])
      );
   end

   fpair_addr #(.AW(AW)) u_addr (
      .form      (form_in),
      .base      (req_base),
      .bytes     (bytes_c),
      .next_base (next_c)
   );

   fpair_legal #(.FRW(FRW), .NSTAT(NSTAT)) u_legal (
      .form      (form_in),
      .p1        (phys[0]),
      .p2        (phys[1]),
      .nat       (req_nat),
      .spec      (req_spec),
      .illegal   (ill_c),
      .nat_fault (natf_c),
      .defer     (def_c),
      .lo_mod    (lo_c),
      .hi_mod    (hi_c)
   );

   assign req_ready = !waiting;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         acc_valid    <= 1'b0;
         acc_addr     <= '0;
         acc_bytes    <= '0;
         base_wr      <= 1'b0;
         base_new     <= '0;
         pf_valid     <= 1'b0;
         pf_addr      <= '0;
         pf_hint      <= '0;
         tgt1         <= '0;
         tgt2         <= '0;
         flt_illegal  <= 1'b0;
         flt_nat      <= 1'b0;
         nat_deferred <= 1'b0;
         mfl_set      <= 1'b0;
         mfh_set      <= 1'b0;
         form_q       <= FORM_SGL;
         waiting      <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            acc_valid    <= !ill_c && !natf_c && !def_c;
            acc_addr     <= req_base;
            acc_bytes    <= bytes_c;
            base_wr      <= req_upd && !ill_c && !natf_c;
            base_new     <= next_c;
            pf_valid     <= req_upd && !ill_c && !natf_c && !def_c;
            pf_addr      <= next_c;
            pf_hint      <= req_hint;
            tgt1         <= phys[0];
            tgt2         <= phys[1];
            flt_illegal  <= ill_c;
            flt_nat      <= natf_c;
            nat_deferred <= def_c;
            mfl_set      <= lo_c;
            mfh_set      <= hi_c;
            form_q       <= form_in;
            waiting      <= !ill_c && !natf_c && !def_c;
         end else if (waiting && beat_valid) begin
            waiting <= 1'b0;
         end
      end
   end

   assign wr_en   = waiting && beat_valid;
   assign wr1_idx = tgt1;
   assign wr2_idx = tgt2;

   always_comb begin
      if (form_q == FORM_SGL) begin
         wr1_data = HALF'(beat_data[QTR-1:0]);
         wr2_data = HALF'(beat_data[HALF-1:QTR]);
      end else begin
         wr1_data = beat_data[HALF-1:0];
         wr2_data = beat_data[DW-1:HALF];
      end
   end
endmodule

// File: rtl/fpair_ld_ctl_chk.sv
module fpair_ld_ctl_chk #(
   parameter int AW  = 64,
   parameter int FRW = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_ready,
   input logic           rsp_valid,
   input logic           acc_valid,
   input logic [AW-1:0]  acc_addr,
   input logic [4:0]     acc_bytes,
   input logic           base_wr,
   input logic [AW-1:0]  base_new,
   input logic           pf_valid,
   input logic [AW-1:0]  pf_addr,
   input logic [FRW-1:0] tgt1,
   input logic [FRW-1:0] tgt2,
   input logic           flt_illegal,
   input logic           flt_nat,
   input logic           nat_deferred,
   input logic           mfl_set,
   input logic           mfh_set,
   input logic           wr_en
);
   AST_ACC_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && acc_valid |-> (acc_bytes == 5'd8 || acc_bytes == 5'd16)); // R1
   AST_UPD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && base_wr |-> (base_new - acc_addr) == AW'(acc_bytes)); // R3
   AST_PF_AT_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> base_wr && acc_valid && pf_addr == base_new); // R5
   AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !flt_illegal |-> tgt1[0] != tgt2[0]); // R7
   AST_FAULT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0({flt_illegal, flt_nat, nat_deferred})); // R8
   AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (flt_illegal || flt_nat) |->
         !acc_valid && !base_wr && !pf_valid && !mfl_set && !mfh_set); // R9
   AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid); // R10
   AST_WRITE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !req_ready); // R11
endmodule

bind fpair_ld_ctl fpair_ld_ctl_chk #(.AW(AW), .FRW(FRW)) chk_i (.*);

// File: tb/fpair_ld_ctl_test.sv
`timescale 1ns/1ps
module fpair_ld_ctl_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [1:0]   req_form = '0;
   logic         req_upd = 1'b0;
   logic         req_spec = 1'b0;
   logic [6:0]   req_f1 = '0;
   logic [6:0]   req_f2 = '0;
   logic [6:0]   req_rrb = '0;
   logic [63:0]  req_base = '0;
   logic         req_nat = 1'b0;
   logic [1:0]   req_hint = '0;
   logic         rsp_valid, acc_valid, base_wr, pf_valid;
   logic [63:0]  acc_addr, base_new, pf_addr;
   logic [4:0]   acc_bytes;
   logic [1:0]   pf_hint;
   logic [6:0]   tgt1, tgt2, wr1_idx, wr2_idx;
   logic         flt_illegal, flt_nat, nat_deferred, mfl_set, mfh_set;
   logic         beat_valid = 1'b0;
   logic [127:0] beat_data = '0;
   logic         wr_en;
   logic [63:0]  wr1_data, wr2_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fpair_ld_ctl uut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int phys(input int s, input int r);
      return (s < 32) ? s : 32 + ((s - 32 + r) % 96);
   endfunction

   function automatic bit lowreg(input int p);
      return p >= 2 && p < 32;
   endfunction

   task automatic do_req(input int form, input bit upd, input bit spec,
                         input int f1, input int f2, input int rrb,
                         input logic [63:0] base, input bit nat, input int hint);
      int p1, p2, bytes;
      bit ill, natf, dfr, ok, acc;
      logic [127:0] beat;
      @(negedge clk);
      chk("R11 ready idle", req_ready, 1);
      req_valid = 1; req_form = 2'(form); req_upd = upd; req_spec = spec;
      req_f1 = 7'(f1); req_f2 = 7'(f2); req_rrb = 7'(rrb);
      req_base = base; req_nat = nat; req_hint = 2'(hint);
      @(posedge clk); #1;
      req_valid = 0;
      p1 = phys(f1, rrb); p2 = phys(f2, rrb);
      ill = (form == 3) || ((p1 % 2) == (p2 % 2));
      natf = !ill && nat && !spec;
      dfr = !ill && nat && spec;
      ok = !ill && !natf;
      acc = ok && !dfr;
      bytes = (form == 0) ? 8 : 16;
      chk("R10 rsp pulse", rsp_valid, 1);
      chk("R6 tgt1", tgt1, 64'(p1));
      chk("R6 tgt2", tgt2, 64'(p2));
      chk("R7 illegal", flt_illegal, 64'(ill));
      chk("R8 nat fault", flt_nat, 64'(natf));
      chk("R8 deferred", nat_deferred, 64'(dfr));
      chk("R9 acc_valid", acc_valid, 64'(acc));
      chk("R1 acc_addr R4", acc_addr, base);
      chk("R1 acc_bytes", acc_bytes, 64'(bytes));
      chk("R3 base_wr", base_wr, 64'(ok && upd));
      if (ok && upd) chk("R3 base_new", base_new, base + 64'(bytes));
      chk("R5 pf_valid", pf_valid, 64'(acc && upd));
      if (acc && upd) begin
         chk("R5 pf_addr", pf_addr, base + 64'(bytes));
         chk("R5 pf_hint", pf_hint, 64'(hint));
      end
      chk("R12 mfl", mfl_set, 64'(ok && (lowreg(p1) || lowreg(p2))));
      chk("R12 mfh", mfh_set, 64'(ok && (p1 >= 32 || p2 >= 32)));
      chk("R11 ready while waiting", req_ready, 64'(!acc));
      if (acc) begin
         beat = {base ^ 64'h5a5a_0f0f_3c3c_9696, ~base};
         beat_data = beat;
         chk("R11 no write before beat", wr_en, 0);
         beat_valid = 1;
         #1;
         chk("R11 wr_en", wr_en, 1);
         chk("R2 wr1_idx", wr1_idx, 64'(p1));
         chk("R2 wr2_idx", wr2_idx, 64'(p2));
         if (form == 0) begin
            chk("R2 single lo", wr1_data, {32'h0, beat[31:0]});
            chk("R2 single hi", wr2_data, {32'h0, beat[63:32]});
         end else begin
            chk("R2 wide lo", wr1_data, beat[63:0]);
            chk("R2 wide hi", wr2_data, beat[127:64]);
         end
         @(posedge clk); #1;
         beat_valid = 0;
         chk("R11 ready after beat", req_ready, 1);
         chk("R10 single pulse", rsp_valid, 0);
      end else begin
         @(posedge clk); #1;
         chk("R10 single pulse", rsp_valid, 0);
         chk("R9 no write after fault", wr_en, 0);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      int rrbs [4] = '{0, 1, 2, 95};
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset rsp", rsp_valid, 0);
      chk("R11 reset ready", req_ready, 1);
      chk("R11 reset wr_en", wr_en, 0);
      @(negedge clk); rst_n = 1;
      // R6 R7 R12: specifier sweep across rotation bases, even and odd
      foreach (rrbs[r]) begin
         for (int f1 = 0; f1 < 128; f1++) begin
            for (int k = 0; k < 4; k++) begin
               do_req((f1 + k) % 3, k[0], 1'b0, f1, (f1 * 37 + k * 29 + 1) % 128,
                      rrbs[r], {32'(f1), 24'(k), 8'hf0}, 1'b0, k);
            end
         end
      end
      // R7: static/rotating mix flips with odd base
      do_req(1, 0, 0, 4, 33, 0, 64'h1000, 0, 0);
      do_req(1, 0, 0, 4, 33, 1, 64'h1000, 0, 0);
      do_req(1, 0, 0, 4, 32, 1, 64'h1000, 0, 0);
      do_req(3, 1, 0, 4, 5, 0, 64'h2000, 0, 1);
      // R3 R4 R5: address wrap and update per form
      do_req(0, 1, 0, 10, 11, 0, 64'hffff_ffff_ffff_fffc, 0, 3);
      do_req(2, 1, 0, 10, 11, 0, 64'hffff_ffff_ffff_fff8, 0, 2);
      do_req(0, 0, 0, 10, 11, 0, 64'h40, 0, 1);
      // R8: NaT non-speculative, speculative, and illegal priority
      do_req(1, 1, 0, 40, 41, 7, 64'h3000, 1, 0);
      do_req(1, 1, 1, 40, 41, 7, 64'h3000, 1, 0);
      do_req(0, 0, 1, 2, 3, 0, 64'h3000, 1, 0);
      do_req(1, 1, 1, 40, 42, 7, 64'h3000, 1, 0);
      do_req(1, 1, 0, 40, 42, 7, 64'h3000, 1, 0);
      done = 1;
      report();
   end
endmodule